// File: doc/BRIEF.md
# Frame Store Access Arbiter

This block decides which of two masters may run the next access to a shared frame store. The first is the display refresh side. It raises a pre-fetch strobe ahead of each line segment. The second is the host/cursor side. It raises a request strobe, or a video-select strobe when the host stripe address enables it. Each side keeps a waiting flag and a granted flag. Only one side holds a grant at a time. Whenever a side is granted and the external phase sequencer reports that it is idle, the arbiter raises a cycle-start request.

When the host side is granted, the arbiter marks the cycle as a host cycle. It also decides, from the two protection flags, the host read qualifier and the out-of-range Y address bit, whether the access may write. The address multiplexer select is made from the sequencer's mux phase and the host-select flag, and it picks one bit out of a 4-bit group for each address line. When the sequencer raises its late acknowledge, the arbiter clears the request it has just served. A write-select signal steers that clear; it combines the host-cycle flag with the parity of the display stripe counter. A falling edge on the line-reset input also drops the refresh request, and an end-of-cycle strobe from the sequencer ends the host-cycle marking.

Top module: `store_arbiter`

## Requirements
- R1: A rising edge on `prefetch_i` sets the refresh waiting flag on that clock edge. On the next edge the refresh side is granted, provided the host side is not granted.
- R2: A rising edge on `host_req_i` sets the host waiting flag. A rising edge on `vid_sel_i` does the same only when `host_stripe_b3_i` is 1 at that edge; otherwise it has no effect.
- R3: At most one side is granted at any time. The host side is granted only while the refresh side is not granted. When both sides are waiting and neither is granted, the refresh side wins.
- R4: On a host grant, `host_sel_o` and `host_cycle_o` become 1. `write_en_o` becomes NOT(`prot_x_i` OR `prot_y_i` OR `host_read_i` OR `host_y_b10_i`), using the values present at the granting edge. On a refresh grant, `host_sel_o` becomes 0.
- R5: `cycle_start_o` is 1 exactly when either side is granted and `store_busy_i` is 0.
- R6: `wr_sel_o` equals NOT(`host_cycle_o` OR `disp_stripe_b0_i`) and follows its inputs without a clock delay.
- R7: At each edge where `late_ack_i` is 1, the host waiting and granted flags clear if `wr_sel_o` is 1; otherwise the refresh flags clear. A clear takes precedence over a set or grant of the same side at that edge.
- R8: Each address output bit i equals `addr_grp_i[4*i + s]`, where s = `mux_phase_i` + 2*`host_sel_o`, with no clock delay.
- R9: A falling edge on `line_rst_i` clears the refresh waiting and granted flags.
- R10: `host_busy_n_o` is 0 while the host waiting flag is set and 1 otherwise.
- R11: A 1 on `cycle_end_i` clears `host_cycle_o` and `write_en_o` at that edge, unless a host grant happens at the same edge.
- R12: After a synchronous reset, both sides are idle, every flag is 0 and `host_busy_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prefetch_i | input | 1 | Refresh request strobe, rising-edge sensitive |
| host_req_i | input | 1 | Host request strobe, rising-edge sensitive |
| vid_sel_i | input | 1 | Video-select strobe, rising-edge sensitive |
| host_stripe_b3_i | input | 1 | Host stripe address bit that enables video-select requests |
| prot_x_i | input | 1 | X protection flag |
| prot_y_i | input | 1 | Y protection flag |
| host_read_i | input | 1 | Host access is a read |
| host_y_b10_i | input | 1 | Host Y address out-of-range bit |
| disp_stripe_b0_i | input | 1 | Parity of the display horizontal stripe counter |
| mux_phase_i | input | 1 | Address mux phase from the sequencer |
| late_ack_i | input | 1 | Sequencer late acknowledge, level |
| cycle_end_i | input | 1 | Sequencer end-of-cycle strobe |
| store_busy_i | input | 1 | Sequencer busy |
| line_rst_i | input | 1 | Line reset, falling-edge sensitive |
| addr_grp_i | input | 4*ADDR_W | One 4-bit source group per address bit |
| refr_wait_o | output | 1 | Refresh waiting flag |
| refr_grant_o | output | 1 | Refresh granted flag |
| host_wait_o | output | 1 | Host waiting flag |
| host_grant_o | output | 1 | Host granted flag |
| host_sel_o | output | 1 | Host-select flag for the address mux |
| host_cycle_o | output | 1 | Host cycle marker |
| write_en_o | output | 1 | Host write permitted |
| wr_sel_o | output | 1 | Write-select steering the served-request clear |
| cycle_start_o | output | 1 | Request to the sequencer to begin a cycle |
| host_busy_n_o | output | 1 | Host busy, active low |
| addr_o | output | ADDR_W | Selected address bits |

## Verification
The bench sweeps all sixteen combinations of the write qualifiers through a real host grant. A design with a wrong polarity or a missing term would mark some protected access as writable. It fires both strobes on the same edge to show that refresh wins and that the host waits until the refresh side is cleared; a design that swapped the priority or allowed a double grant shows up there. Every select index is checked against several address patterns for both host-select states, so a swapped select bit gives wrong address bits. The bench also covers the video-select strobe with its enable bit low, the clear steered by stripe parity in both directions, and the clear on the falling edge of line reset, each of which a careless edge or polarity choice would break.

// File: rtl/store_arb_pkg.sv
// Shared definitions for the frame store arbiter.
// Assumes a fixed group of four candidate sources per address bit.
package store_arb_pkg;
    localparam int GRP_W  = 4;
    localparam int SEL_W  = 2;

    // Builds the address-group index from mux phase and host select.
    function automatic logic [SEL_W-1:0] grp_index(input logic phase, input logic hsel);
        return {hsel, phase};
    endfunction
endpackage

// File: rtl/store_arb_edge.sv
// Edge detector bank: registers each input and reports rising/falling edges
// relative to the previous sampled value. Assumes inputs are synchronous.
module store_arb_edge #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    // Holds the previous value of every input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_i;
    end

    // Edge flags compare the current input against the held copy.
    always_comb begin
        rise_o = sig_i & ~prev_q;
        fall_o = ~sig_i & prev_q;
    end
endmodule

// File: rtl/store_arb_core.sv
// Request and grant state for the refresh and host sides.
// Assumes set strobes are single-cycle edge flags. Clears beat sets and
// grants, and refresh beats host when both could be granted together.
module store_arb_core (
    input  logic clk,
    input  logic rst_n,
    input  logic refr_set_i,
    input  logic host_set_i,
    input  logic refr_drop_i,
    input  logic late_ack_i,
    input  logic wr_sel_i,
    input  logic cycle_end_i,
    input  logic wr_block_i,
    output logic refr_wait_o,
    output logic refr_grant_o,
    output logic host_wait_o,
    output logic host_grant_o,
    output logic host_sel_o,
    output logic host_cycle_o,
    output logic write_en_o
);
    logic refr_go, host_go, refr_clr, host_clr;

    // Grant decision from registered state, refresh first.
    always_comb begin
        refr_go  = refr_wait_o & ~refr_grant_o & ~host_grant_o;
        host_go  = host_wait_o & ~host_grant_o & ~refr_grant_o & ~refr_go;
        refr_clr = refr_drop_i | (late_ack_i & ~wr_sel_i);
        host_clr = late_ack_i & wr_sel_i;
    end

    // Refresh waiting and granted flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refr_wait_o  <= 1'b0;
            refr_grant_o <= 1'b0;
        end else if (refr_clr) begin
            refr_wait_o  <= 1'b0;
            refr_grant_o <= 1'b0;
        end else begin
            if (refr_set_i) refr_wait_o  <= 1'b1;
            if (refr_go)    refr_grant_o <= 1'b1;
        end
    end

    // Host waiting and granted flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_wait_o  <= 1'b0;
            host_grant_o <= 1'b0;
        end else if (host_clr) begin
            host_wait_o  <= 1'b0;
            host_grant_o <= 1'b0;
        end else begin
            if (host_set_i) host_wait_o  <= 1'b1;
            if (host_go)    host_grant_o <= 1'b1;
        end
    end

    // Host select, host-cycle marker and write permission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_sel_o   <= 1'b0;
            host_cycle_o <= 1'b0;
            write_en_o   <= 1'b0;
        end else if (host_go && !host_clr) begin
            host_sel_o   <= 1'b1;
            host_cycle_o <= 1'b1;
            write_en_o   <= ~wr_block_i;
        end else begin
            if (refr_go && !refr_clr) host_sel_o <= 1'b0;
            if (cycle_end_i) begin
                host_cycle_o <= 1'b0;
                write_en_o   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/store_arb_addr.sv
// Address select: each output bit picks one bit of its own 4-bit group.
// Assumes the group index is already formed from phase and host select.
module store_arb_addr
    import store_arb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [GRP_W*ADDR_W-1:0] grp_i,
    input  logic [SEL_W-1:0]        idx_i,
    output logic [ADDR_W-1:0]       addr_o
);
    for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_bit
        logic [GRP_W-1:0] grp;
        // Slices this bit's group and selects one entry.
        always_comb begin
            grp        = grp_i[gi*GRP_W +: GRP_W];
            addr_o[gi] = grp[idx_i];
        end
    end
endmodule

// File: rtl/store_arbiter.sv
// Top of the frame store arbiter. Detects request edges, holds the grant
// state, forms write-select and cycle-start, and drives the address mux.
// Assumes all inputs are synchronous to clk.
module store_arbiter
    import store_arb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prefetch_i,
    input  logic                    host_req_i,
    input  logic                    vid_sel_i,
    input  logic                    host_stripe_b3_i,
    input  logic                    prot_x_i,
    input  logic                    prot_y_i,
    input  logic                    host_read_i,
    input  logic                    host_y_b10_i,
    input  logic                    disp_stripe_b0_i,
    input  logic                    mux_phase_i,
    input  logic                    late_ack_i,
    input  logic                    cycle_end_i,
    input  logic                    store_busy_i,
    input  logic                    line_rst_i,
    input  logic [4*ADDR_W-1:0]     addr_grp_i,
    output logic                    refr_wait_o,
    output logic                    refr_grant_o,
    output logic                    host_wait_o,
    output logic                    host_grant_o,
    output logic                    host_sel_o,
    output logic                    host_cycle_o,
    output logic                    write_en_o,
    output logic                    wr_sel_o,
    output logic                    cycle_start_o,
    output logic                    host_busy_n_o,
    output logic [ADDR_W-1:0]       addr_o
);
    localparam int NEDGE = 4;

    logic [NEDGE-1:0] rise, fall;
    logic             wr_block;
    logic [SEL_W-1:0] idx;

    store_arb_edge #(.N(NEDGE)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i ({line_rst_i, vid_sel_i, host_req_i, prefetch_i}),
        .rise_o(rise),
        .fall_o(fall)
    );

    // Combines the write blockers and the combinational status outputs.
    always_comb begin
        wr_block      = prot_x_i | prot_y_i | host_read_i | host_y_b10_i;
        wr_sel_o      = ~(host_cycle_o | disp_stripe_b0_i);
        cycle_start_o = (refr_grant_o | host_grant_o) & ~store_busy_i;
        host_busy_n_o = ~host_wait_o;
        idx           = grp_index(mux_phase_i, host_sel_o);
    end

    store_arb_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .refr_set_i  (rise[0]),
        .host_set_i  (rise[1] | (rise[2] & host_stripe_b3_i)),
        .refr_drop_i (fall[3]),
        .late_ack_i  (late_ack_i),
        .wr_sel_i    (wr_sel_o),
        .cycle_end_i (cycle_end_i),
        .wr_block_i  (wr_block),
        .refr_wait_o (refr_wait_o),
        .refr_grant_o(refr_grant_o),
        .host_wait_o (host_wait_o),
        .host_grant_o(host_grant_o),
        .host_sel_o  (host_sel_o),
        .host_cycle_o(host_cycle_o),
        .write_en_o  (write_en_o)
    );

    store_arb_addr #(.ADDR_W(ADDR_W)) u_addr (
        .grp_i (addr_grp_i),
        .idx_i (idx),
        .addr_o(addr_o)
    );
endmodule

// File: rtl/store_arbiter_chk.sv
// Property checker for the frame store arbiter, bound to every instance.
module store_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic refr_grant_o,
    input logic host_grant_o,
    input logic host_wait_o,
    input logic refr_wait_o,
    input logic host_sel_o,
    input logic host_cycle_o,
    input logic write_en_o,
    input logic wr_sel_o,
    input logic late_ack_i,
    input logic store_busy_i,
    input logic cycle_start_o,
    input logic prot_x_i,
    input logic prot_y_i,
    input logic host_read_i,
    input logic host_y_b10_i
);
    a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({refr_grant_o, host_grant_o}));

    a_r4_host_grant_marks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_grant_o) |-> host_sel_o && host_cycle_o);

    a_r4_write_decision: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_grant_o) |->
            write_en_o == !$past(prot_x_i || prot_y_i || host_read_i || host_y_b10_i));

    a_r4_refr_grant_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refr_grant_o) |-> !host_sel_o);

    a_r5_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |-> !store_busy_i);

    a_r7_clear_host: assert property (@(posedge clk) disable iff (!rst_n)
        late_ack_i && wr_sel_o |=> !host_grant_o && !host_wait_o);

    a_r7_clear_refr: assert property (@(posedge clk) disable iff (!rst_n)
        late_ack_i && !wr_sel_o |=> !refr_grant_o && !refr_wait_o);
endmodule

bind store_arbiter store_arbiter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .refr_grant_o (refr_grant_o),
    .host_grant_o (host_grant_o),
    .host_wait_o  (host_wait_o),
    .refr_wait_o  (refr_wait_o),
    .host_sel_o   (host_sel_o),
    .host_cycle_o (host_cycle_o),
    .write_en_o   (write_en_o),
    .wr_sel_o     (wr_sel_o),
    .late_ack_i   (late_ack_i),
    .store_busy_i (store_busy_i),
    .cycle_start_o(cycle_start_o),
    .prot_x_i     (prot_x_i),
    .prot_y_i     (prot_y_i),
    .host_read_i  (host_read_i),
    .host_y_b10_i (host_y_b10_i)
);

// File: tb/tb_store_arbiter.sv
module tb_store_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic prefetch_i, host_req_i, vid_sel_i, host_stripe_b3_i;
    logic prot_x_i, prot_y_i, host_read_i, host_y_b10_i;
    logic disp_stripe_b0_i, mux_phase_i, late_ack_i, cycle_end_i;
    logic store_busy_i, line_rst_i;
    logic [4*ADDR_W-1:0] addr_grp_i;
    logic refr_wait_o, refr_grant_o, host_wait_o, host_grant_o;
    logic host_sel_o, host_cycle_o, write_en_o, wr_sel_o;
    logic cycle_start_o, host_busy_n_o;
    logic [ADDR_W-1:0] addr_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_arbiter #(.ADDR_W(ADDR_W)) dut (.*);

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD*100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Serves the refresh side: parity 1 makes write-select 0 while host cycle is 0.
    task automatic clear_refr();
        disp_stripe_b0_i = 1'b1;
        late_ack_i = 1'b1;
        tick();
        late_ack_i = 1'b0;
    endtask

    // Ends a host cycle, then serves the host side with write-select 1.
    task automatic clear_host();
        cycle_end_i = 1'b1;
        tick();
        cycle_end_i = 1'b0;
        disp_stripe_b0_i = 1'b0;
        late_ack_i = 1'b1;
        tick();
        late_ack_i = 1'b0;
    endtask

    task automatic pulse_host();
        host_req_i = 1'b1;
        tick();
        host_req_i = 1'b0;
    endtask

    task automatic pulse_refr();
        prefetch_i = 1'b1;
        tick();
        prefetch_i = 1'b0;
    endtask

    // Checks every address bit for the current select inputs.
    task automatic chk_addr(input logic hsel);
        for (int ph = 0; ph < 2; ph++) begin
            for (int p = 0; p < 6; p++) begin
                logic [ADDR_W-1:0] exp;
                int idx;
                mux_phase_i = ph[0];
                addr_grp_i  = 32'h9E37_79B9 * (p + 1) + p * 32'h0101_0101;
                #1;
                idx = ph + 2 * hsel;
                for (int b = 0; b < ADDR_W; b++) exp[b] = addr_grp_i[4*b + idx];
                chk("R8 addr select", addr_o, exp);
            end
        end
        mux_phase_i = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        prefetch_i = 0; host_req_i = 0; vid_sel_i = 0; host_stripe_b3_i = 0;
        prot_x_i = 0; prot_y_i = 0; host_read_i = 0; host_y_b10_i = 0;
        disp_stripe_b0_i = 0; mux_phase_i = 0; late_ack_i = 0; cycle_end_i = 0;
        store_busy_i = 0; line_rst_i = 0; addr_grp_i = '0;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;

        // R12 reset state
        chk("R12 idle flags", {refr_wait_o, refr_grant_o, host_wait_o, host_grant_o,
                               host_sel_o, host_cycle_o, write_en_o, cycle_start_o}, 0);
        chk("R12 host busy", host_busy_n_o, 1);
        chk("R6 wsel at reset", wr_sel_o, 1);

        // R1 refresh request and grant timing
        pulse_refr();
        chk("R1 refresh wait", refr_wait_o, 1);
        chk("R1 not yet granted", refr_grant_o, 0);
        tick();
        chk("R1 refresh grant", refr_grant_o, 1);
        chk("R4 refresh sel", host_sel_o, 0);
        chk("R5 start idle", cycle_start_o, 1);
        store_busy_i = 1'b1; #1;
        chk("R5 start busy", cycle_start_o, 0);
        store_busy_i = 1'b0;
        chk_addr(1'b0);
        clear_refr();
        chk("R7 refresh cleared", {refr_wait_o, refr_grant_o}, 0);
        chk("R5 no start", cycle_start_o, 0);

        // R2 video-select without enable bit is ignored
        host_stripe_b3_i = 1'b0;
        vid_sel_i = 1'b1; tick(); vid_sel_i = 1'b0; tick();
        chk("R2 vidsel ignored", {host_wait_o, host_grant_o}, 0);
        chk("R10 busy stays high", host_busy_n_o, 1);
        // R2 video-select with enable bit
        host_stripe_b3_i = 1'b1;
        vid_sel_i = 1'b1; tick(); vid_sel_i = 1'b0;
        chk("R2 vidsel wait", host_wait_o, 1);
        chk("R10 busy low", host_busy_n_o, 0);
        tick();
        chk("R2 vidsel grant", host_grant_o, 1);
        host_stripe_b3_i = 1'b0;
        clear_host();
        chk("R7 host cleared", {host_wait_o, host_grant_o}, 0);
        chk("R10 busy released", host_busy_n_o, 1);

        // R4 sweep of all write qualifier combinations through host grants
        for (int v = 0; v < 16; v++) begin
            pulse_host();
            {prot_x_i, prot_y_i, host_read_i, host_y_b10_i} = v[3:0];
            tick();
            chk("R4 host grant", host_grant_o, 1);
            chk("R4 host marks", {host_sel_o, host_cycle_o}, 2'b11);
            chk("R4 write enable", write_en_o, (v == 0) ? 1 : 0);
            // R6 with host cycle high write-select is 0 for both parities
            disp_stripe_b0_i = v[0]; #1;
            chk("R6 wsel host cycle", wr_sel_o, 0);
            {prot_x_i, prot_y_i, host_read_i, host_y_b10_i} = 4'b0;
            clear_host();
            chk("R11 cycle ended", {host_cycle_o, write_en_o}, 0);
            chk("R7 host served", {host_wait_o, host_grant_o}, 0);
        end

        // R8 with host select set
        chk_addr(1'b1);

        // R6 combinational parity when no host cycle
        disp_stripe_b0_i = 1'b1; #1;
        chk("R6 wsel parity1", wr_sel_o, 0);
        disp_stripe_b0_i = 1'b0; #1;
        chk("R6 wsel parity0", wr_sel_o, 1);

        // R3 simultaneous requests: refresh wins, host waits
        prefetch_i = 1'b1; host_req_i = 1'b1;
        tick();
        prefetch_i = 1'b0; host_req_i = 1'b0;
        chk("R3 both wait", {refr_wait_o, host_wait_o}, 2'b11);
        tick();
        chk("R3 refresh first", {refr_grant_o, host_grant_o}, 2'b10);
        tick();
        chk("R3 host blocked", host_grant_o, 0);
        // R7 late ack with write-select 1 clears host, not refresh
        disp_stripe_b0_i = 1'b0; late_ack_i = 1'b1; tick(); late_ack_i = 1'b0;
        chk("R7 steer host", {refr_grant_o, host_wait_o, host_grant_o}, 3'b100);
        // R9 line reset falling edge clears refresh
        line_rst_i = 1'b1; tick();
        chk("R9 rise no effect", refr_grant_o, 1);
        line_rst_i = 1'b0; tick();
        chk("R9 fall clears", {refr_wait_o, refr_grant_o}, 0);

        // R3 host granted blocks later refresh request
        pulse_host(); tick();
        chk("R3 host granted", host_grant_o, 1);
        pulse_refr(); tick();
        chk("R3 refresh blocked", {refr_wait_o, refr_grant_o}, 2'b10);
        clear_host();
        tick();
        chk("R1 refresh after host", refr_grant_o, 1);
        chk("R4 sel back to refresh", host_sel_o, 0);
        clear_refr();
        chk("R7 final clear", {refr_wait_o, refr_grant_o, host_wait_o, host_grant_o}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule